// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 32-bit register file and a 32-bit little-endian data memory port. On the load side it takes the word read from memory, uses the low address bits to pick out the addressed byte, halfword or word, and widens the result to 32 bits. Whether the upper bits are filled with zeros or with copies of the loaded value's top bit depends on the access type. The load path has no register on it, so the result is valid in the same cycle as the read word.

On the store side it copies the low byte or halfword of the source register into every lane of the write word. It also builds a per-byte write-enable mask that covers only the addressed lanes. The mask, the write data and the word address are registered once before they reach the memory port.

A three-bit access code selects the access:

- Bits 1:0 give the size: 00 is byte, 01 is halfword, 10 is word, and 11 is treated as word.
- Bit 2 set means the load is zero-extended. Bit 2 clear means it is sign-extended.

A combinational misalignment flag is raised for badly aligned halfword and word accesses. A misaligned store writes nothing.

Top module: `ldst_lane_aligner`

## Requirements
- R1: A word access (size 10 or 11) with address bits 1:0 equal to 00 returns the whole memory read word on the load result, in the same cycle with no clock edge.
- R2: A zero-extended byte load (code 100) puts memory bits [8*a+7:8*a] in result bits 7:0, where a is address bits 1:0, and clears result bits 31:8.
- R3: A zero-extended halfword load (code 101) with address bit 0 clear puts memory bits [16*h+15:16*h] in result bits 15:0, where h is address bit 1, and clears result bits 31:16.
- R4: A sign-extended byte load (code 000) takes the same lane as R2 and fills result bits 31:8 with bit 7 of that byte.
- R5: A sign-extended halfword load (code 001) with address bit 0 clear takes the same lane as R3 and fills result bits 31:16 with bit 15 of that halfword.
- R6: The misalign output is high in the same cycle exactly when a halfword access has address bit 0 set, or a word access has address bits 1:0 not equal to 00. Byte accesses never raise it.
- R7: While the misalign output is high, the load result is all zeros.
- R8: A byte store request raises write-enable bit a (a = address bits 1:0) and no other bit on the next clock edge. The write data carries the low source byte in all four lanes.
- R9: A halfword store request with address bit 1 clear gives enables 0011, and with address bit 1 set gives enables 1100, on the next edge. The write data carries the low source halfword in both halves.
- R10: An aligned word store request gives enables 1111 and the unchanged source word as write data on the next edge.
- R11: A cycle with no store request, or with a misaligned store request, gives enables 0000 and the write strobe low after the next edge.
- R12: While reset is high, the enables, the write strobe, the write data and the word address are all zero after each clock edge.
- R13: An enabled store presents address bits 31:2 on the word-address output after the next edge. The write strobe is high exactly when any enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Access code: bits 1:0 size, bit 2 zero-extend |
| addr_i | input | 32 | Byte address of the access |
| ld_rdata_i | input | 32 | Word read from memory |
| ld_data_o | output | 32 | Aligned and extended load result (combinational) |
| misalign_o | output | 1 | Misaligned access flag (combinational) |
| st_req_i | input | 1 | Store request this cycle |
| st_src_i | input | 32 | Source register value for stores |
| mem_waddr_o | output | 30 | Registered word address for the write |
| mem_be_o | output | 4 | Registered per-byte write enables |
| mem_we_o | output | 1 | Registered write strobe |
| mem_wdata_o | output | 32 | Registered lane-replicated write data |

## Verification
The load side holds no state. A wrong lane pick, a wrong extension bit or a wrong misalign decision shows up on the load result or the misalign output within the same cycle as the access code and address that expose it. The store side has one register stage. A corrupted enable mask, data word, address or strobe appears at the memory port on the edge right after the request, and it is overwritten by the next request one edge later. So every fault can be observed within one clock of the stimulus that triggers it. The reference model compares every output in every cycle, across all access codes, all four byte offsets, both extension polarities and stores that are suppressed.

// File: rtl/ldst_lane_pkg.sv
package ldst_lane_pkg;

    localparam int LANE_W     = 8;
    localparam int LANES      = 4;
    localparam int DATA_W     = LANE_W * LANES;
    localparam int HALF_W     = 2 * LANE_W;
    localparam int HALVES     = LANES / 2;
    localparam int LANE_IDX_W = $clog2(LANES);
    localparam int OP_W       = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef struct packed {
        size_e                  size;
        logic                   zext;
        logic [LANE_IDX_W-1:0]  lane;
        logic                   misalign;
    } access_t;

    typedef struct packed {
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] data;
    } wr_beat_t;

    // Reserved size code behaves as a full word.
    function automatic size_e norm_size(input logic [1:0] raw);
        size_e s;
        case (raw)
            2'b00:   s = SZ_BYTE;
            2'b01:   s = SZ_HALF;
            default: s = SZ_WORD;
        endcase
        return s;
    endfunction

    // Widen the low 'width' bits of v, filling with zero or the top bit.
    function automatic logic [DATA_W-1:0] extend_low(
        input logic [DATA_W-1:0] v,
        input int unsigned       width,
        input logic              zext
    );
        logic [DATA_W-1:0] r;
        logic              fill;
        fill = zext ? 1'b0 : v[width-1];
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = (i < int'(width)) ? v[i] : fill;
        end
        return r;
    endfunction

    function automatic logic [LANES-1:0] lane_mask(
        input size_e                 sz,
        input logic [LANE_IDX_W-1:0] lane
    );
        logic [LANES-1:0] m;
        case (sz)
            SZ_BYTE: m = LANES'(1) << lane;
            SZ_HALF: m = LANES'(3) << (lane & ~LANE_IDX_W'(1));
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] replicate_low(
        input size_e             sz,
        input logic [DATA_W-1:0] d
    );
        logic [DATA_W-1:0] r;
        r = d;
        case (sz)
            SZ_BYTE: for (int i = 0; i < LANES; i++) r[i*LANE_W +: LANE_W] = d[LANE_W-1:0];
            SZ_HALF: for (int i = 0; i < HALVES; i++) r[i*HALF_W +: HALF_W] = d[HALF_W-1:0];
            default: r = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ldst_access_decode.sv
module ldst_access_decode
    import ldst_lane_pkg::*;
(
    input  logic [OP_W-1:0]       op_i,
    input  logic [LANE_IDX_W-1:0] addr_lo_i,
    output access_t               acc_o
);

    size_e sz;

    always_comb begin
        sz            = norm_size(op_i[1:0]);
        acc_o.size    = sz;
        acc_o.zext    = op_i[2];
        acc_o.lane    = addr_lo_i;
        case (sz)
            SZ_HALF: acc_o.misalign = addr_lo_i[0];
            SZ_BYTE: acc_o.misalign = 1'b0;
            default: acc_o.misalign = (addr_lo_i != '0);
        endcase
    end

endmodule

// File: rtl/ldst_load_extract.sv
module ldst_load_extract
    import ldst_lane_pkg::*;
(
    input  access_t           acc_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] data_o
);

    logic [LANE_W-1:0] byte_lane [LANES];
    logic [HALF_W-1:0] half_lane [HALVES];

    for (genvar g = 0; g < LANES; g++) begin : g_byte
        assign byte_lane[g] = rdata_i[g*LANE_W +: LANE_W];
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign half_lane[h] = rdata_i[h*HALF_W +: HALF_W];
    end

    logic [DATA_W-1:0] picked;

    always_comb begin
        case (acc_i.size)
            SZ_BYTE: picked = extend_low(DATA_W'(byte_lane[acc_i.lane]), LANE_W, acc_i.zext);
            SZ_HALF: picked = extend_low(DATA_W'(half_lane[acc_i.lane[LANE_IDX_W-1:1]]),
                                         HALF_W, acc_i.zext);
            default: picked = rdata_i;
        endcase
        data_o = acc_i.misalign ? '0 : picked;
    end

endmodule

// File: rtl/ldst_store_format.sv
module ldst_store_format
    import ldst_lane_pkg::*;
#(
    parameter int WADDR_W = 30
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_i,
    input  size_e                 size_i,
    input  logic [LANE_IDX_W-1:0] lane_i,
    input  logic                  misalign_i,
    input  logic [DATA_W-1:0]     src_i,
    input  logic [WADDR_W-1:0]    waddr_i,
    output logic [WADDR_W-1:0]    waddr_o,
    output logic [LANES-1:0]      be_o,
    output logic                  we_o,
    output logic [DATA_W-1:0]     wdata_o
);

    wr_beat_t nxt;

    always_comb begin
        nxt.be   = (req_i && !misalign_i) ? lane_mask(size_i, lane_i) : '0;
        nxt.data = replicate_low(size_i, src_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            be_o    <= '0;
            we_o    <= 1'b0;
            wdata_o <= '0;
            waddr_o <= '0;
        end else begin
            be_o    <= nxt.be;
            we_o    <= |nxt.be;
            wdata_o <= nxt.data;
            waddr_o <= waddr_i;
        end
    end

endmodule

// File: rtl/ldst_lane_aligner.sv
module ldst_lane_aligner
    import ldst_lane_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [OP_W-1:0]              op_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [DATA_W-1:0]            ld_rdata_i,
    output logic [DATA_W-1:0]            ld_data_o,
    output logic                         misalign_o,
    input  logic                         st_req_i,
    input  logic [DATA_W-1:0]            st_src_i,
    output logic [ADDR_W-LANE_IDX_W-1:0] mem_waddr_o,
    output logic [LANES-1:0]             mem_be_o,
    output logic                         mem_we_o,
    output logic [DATA_W-1:0]            mem_wdata_o
);

    localparam int WADDR_W = ADDR_W - LANE_IDX_W;

    access_t acc;

    ldst_access_decode u_dec (
        .op_i      (op_i),
        .addr_lo_i (addr_i[LANE_IDX_W-1:0]),
        .acc_o     (acc)
    );

    ldst_load_extract u_ld (
        .acc_i   (acc),
        .rdata_i (ld_rdata_i),
        .data_o  (ld_data_o)
    );

    ldst_store_format #(.WADDR_W(WADDR_W)) u_st (
        .clk        (clk),
        .rst        (rst),
        .req_i      (st_req_i),
        .size_i     (acc.size),
        .lane_i     (acc.lane),
        .misalign_i (acc.misalign),
        .src_i      (st_src_i),
        .waddr_i    (addr_i[ADDR_W-1:LANE_IDX_W]),
        .waddr_o    (mem_waddr_o),
        .be_o       (mem_be_o),
        .we_o       (mem_we_o),
        .wdata_o    (mem_wdata_o)
    );

    assign misalign_o = acc.misalign;

endmodule

// File: rtl/ldst_lane_aligner_chk.sv
module ldst_lane_aligner_chk #(
    parameter int ADDR_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic [2:0]          op_i,
    input logic [ADDR_W-1:0]   addr_i,
    input logic [31:0]         ld_data_o,
    input logic                misalign_o,
    input logic                st_req_i,
    input logic [31:0]         st_src_i,
    input logic [ADDR_W-3:0]   mem_waddr_o,
    input logic [3:0]          mem_be_o,
    input logic                mem_we_o,
    input logic [31:0]         mem_wdata_o
);

    // R2
    ubyte_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b100) |-> (ld_data_o[31:8] == 24'h0));

    // R4
    sbyte_sign_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'b000) |-> (ld_data_o[31:8] == {24{ld_data_o[7]}}));

    // R7
    misalign_zero_load_chk: assert property (@(posedge clk) disable iff (rst)
        misalign_o |-> (ld_data_o == 32'h0));

    // R8
    byte_store_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (st_req_i && op_i[1:0] == 2'b00) |=> ($countones(mem_be_o) == 1 && mem_we_o));

    // R9
    half_store_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (st_req_i && op_i[1:0] == 2'b01 && !misalign_o)
        |=> (mem_be_o == 4'b0011 || mem_be_o == 4'b1100));

    // R10
    word_store_full_chk: assert property (@(posedge clk) disable iff (rst)
        (st_req_i && op_i[1] && !misalign_o)
        |=> (mem_be_o == 4'hF && mem_wdata_o == $past(st_src_i)));

    // R11
    suppressed_store_chk: assert property (@(posedge clk) disable iff (rst)
        (!st_req_i || misalign_o) |=> (mem_be_o == 4'h0 && !mem_we_o));

    // R13
    store_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (st_req_i && !misalign_o) |=> (mem_waddr_o == $past(addr_i[ADDR_W-1:2])));

endmodule

bind ldst_lane_aligner ldst_lane_aligner_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .op_i        (op_i),
    .addr_i      (addr_i),
    .ld_data_o   (ld_data_o),
    .misalign_o  (misalign_o),
    .st_req_i    (st_req_i),
    .st_src_i    (st_src_i),
    .mem_waddr_o (mem_waddr_o),
    .mem_be_o    (mem_be_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o)
);

// File: tb/ldst_lane_aligner_tb_top.sv
module ldst_lane_aligner_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op;
    logic [31:0] addr, rdata, src;
    logic        req;
    logic [31:0] ld_data, wdata;
    logic        mis, we;
    logic [29:0] waddr;
    logic [3:0]  be;

    always #5 clk = ~clk;

    ldst_lane_aligner dut_i (
        .clk(clk), .rst(rst), .op_i(op), .addr_i(addr), .ld_rdata_i(rdata),
        .ld_data_o(ld_data), .misalign_o(mis), .st_req_i(req), .st_src_i(src),
        .mem_waddr_o(waddr), .mem_be_o(be), .mem_we_o(we), .mem_wdata_o(wdata)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // expected registered outputs for the next sampling point
    logic [3:0]  e_be;
    logic        e_we;
    logic [31:0] e_wdata;
    logic [29:0] e_waddr;
    string       e_tag;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int eff_size(logic [2:0] o);
        return (o[1:0] == 2'b11) ? 2 : int'(o[1:0]);
    endfunction

    function automatic bit ref_mis(logic [2:0] o, logic [31:0] a);
        int s = eff_size(o);
        return (s == 1 && a[0]) || (s == 2 && a[1:0] != 2'b00);
    endfunction

    function automatic logic [31:0] ref_load(logic [2:0] o, logic [31:0] a, logic [31:0] rd);
        int s = eff_size(o);
        int shamt;
        logic [31:0] msk, v;
        if (ref_mis(o, a)) return 32'h0;
        if (s == 2) return rd;
        shamt = (s == 0) ? 8 * int'(a[1:0]) : 16 * int'(a[1]);
        msk   = (s == 0) ? 32'h0000_00FF : 32'h0000_FFFF;
        v     = (rd >> shamt) & msk;
        if (!o[2] && ((v & ~(msk >> 1)) != 0)) v = v | ~msk;
        return v;
    endfunction

    function automatic string load_tag(logic [2:0] o, logic [31:0] a);
        int s = eff_size(o);
        if (ref_mis(o, a)) return "R7";
        if (s == 2) return "R1";
        if (s == 0) return o[2] ? "R2" : "R4";
        return o[2] ? "R3" : "R5";
    endfunction

    task automatic step(logic [2:0] o, logic [31:0] a, logic [31:0] rd, logic rq, logic [31:0] s);
        int sz;
        @(negedge clk);
        check(e_tag, "mem_be", 32'(be), 32'(e_be));
        check(e_tag, "mem_we", 32'(we), 32'(e_we));
        if (e_we) begin
            check(e_tag, "mem_wdata", wdata, e_wdata);
            check("R13", "mem_waddr", 32'(waddr), 32'(e_waddr));
        end
        op = o; addr = a; rdata = rd; req = rq; src = s;
        #1;
        check("R6", "misalign", 32'(mis), 32'(ref_mis(o, a)));
        check(load_tag(o, a), "ld_data", ld_data, ref_load(o, a, rd));
        sz = eff_size(o);
        if (!rq || ref_mis(o, a)) begin
            e_be = 4'h0; e_we = 1'b0; e_tag = "R11";
        end else begin
            e_we    = 1'b1;
            e_waddr = a[31:2];
            case (sz)
                0: begin e_be = 4'b0001 << a[1:0]; e_wdata = {4{s[7:0]}};  e_tag = "R8";  end
                1: begin e_be = a[1] ? 4'b1100 : 4'b0011; e_wdata = {2{s[15:0]}}; e_tag = "R9"; end
                default: begin e_be = 4'hF; e_wdata = s; e_tag = "R10"; end
            endcase
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        op = 3'b010; addr = 32'h0000_1000; rdata = 32'h1234_5678; req = 1'b1; src = 32'hDEAD_BEEF;
        // R12: reset dominates a pending word store
        repeat (3) begin
            @(negedge clk);
            check("R12", "mem_be", 32'(be), 32'h0);
            check("R12", "mem_we", 32'(we), 32'h0);
            check("R12", "mem_wdata", wdata, 32'h0);
            check("R12", "mem_waddr", 32'(waddr), 32'h0);
        end
        rst = 1'b0; req = 1'b0;
        e_be = 4'h0; e_we = 1'b0; e_wdata = 32'h0; e_waddr = 30'h0; e_tag = "R12";

        // directed sweep: every code, every offset, two data polarities
        for (int oi = 0; oi < 8; oi++) begin
            for (int off = 0; off < 4; off++) begin
                step(3'(oi), 32'h0000_2A40 | 32'(off), 32'h80FF_7F01, 1'b1, 32'hA5C3_817E);
                step(3'(oi), 32'h8000_0100 | 32'(off), 32'h7F80_01FE, (off % 2) == 0, 32'h0102_F3C4);
            end
        end

        // pseudo-random traffic
        for (int k = 0; k < 400; k++) begin
            step(3'($urandom), $urandom, $urandom, 1'($urandom), $urandom);
        end
        step(3'b000, 32'h0, 32'h0, 1'b0, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule